// File: doc/BRIEF.md
# Handshaked PHY Control-Bus Master

This block is a hardware master for a narrow register bus that reaches into a serial PHY's internal configuration space. The bus carries one 16-bit value toward the PHY and four single-bit strobes: address capture, data capture, read and write. It returns a 16-bit read value and a single acknowledge line. Every transfer on this bus is a four-phase exchange. The master raises a strobe, waits for the acknowledge to go high, drops the strobe, and waits for the acknowledge to go low.

Commands arrive on a valid/ready request port and can be read, write or read-modify-write. The master turns each command into a chain of these exchanges:

- A read is an address phase followed by a read phase.
- A write is an address phase, a data-capture phase and a write-strobe phase.
- A read-modify-write runs a complete read, merges the new bits, and then runs a complete write to the same address.

The acknowledge passes through a synchronizer and is sampled at a fixed interval. If an edge does not appear within a bounded number of samples, the command is abandoned and reported as an error. Each command ends with a single-cycle response that carries the read data and an error flag.

Top module: `regbus_master`

## Requirements
- R1: An address phase drives the address on `bus_wval` with no strobe for two cycles, then raises `bus_cap_addr`. It holds the strobe until the synchronized acknowledge is seen high. It then lowers the strobe, keeps the address on `bus_wval`, and waits for the acknowledge to be seen low.
- R2: Opcode 0 (read) performs an address phase and then a read phase. The read phase drives `bus_wval` to zero with `bus_rd_stb` high. On the sample that sees the acknowledge high it captures `bus_rval`, and that value is returned on `rsp_rdata`. Opcode 3 behaves exactly like opcode 0.
- R3: Opcode 1 (write) performs an address phase, then a data-capture phase on `bus_cap_data` using the same handshake as R1 with the write value, then a write-strobe phase. The write strobe rises only after the write value has been on `bus_wval` for at least one cycle, and the value is held while the strobe is high. `rsp_rdata` is zero for a write.
- R4: Opcode 2 (read-modify-write) reads the addressed register, computes `(read & ~req_mask) | req_wdata`, and writes the result to the same address. `rsp_rdata` returns the value that was read.
- R5: Each wait on an acknowledge edge allows `SAMPLE_LIMIT` samples, taken every `SAMPLE_CYCLES` clocks. If the expected level appears on the last allowed sample, the phase still succeeds. If it has not appeared by then, the command ends at once with `rsp_err` high and `rsp_rdata` zero, no later strobe is issued, and all strobes are low.
- R6: At most one of the four strobes is high in any cycle.
- R7: `req_ready` is high only while idle, so at most one command is outstanding. A request held valid during a busy period is accepted only after the earlier response. `rsp_valid` is a one-cycle pulse, and `req_ready` is low in that cycle.
- R8: While `rst` is high, the block returns to idle with all strobes low, `req_ready` high and `rsp_valid` low, even in the middle of a command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Command request valid |
| req_ready | output | 1 | Master idle, command accepted when valid |
| req_op | input | 2 | 0 read, 1 write, 2 read-modify-write, 3 read |
| req_addr | input | DATA_W | Target register address |
| req_wdata | input | DATA_W | Write value, or bits to OR in for read-modify-write |
| req_mask | input | DATA_W | Bits cleared before merge (read-modify-write only) |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Command aborted by acknowledge timeout |
| rsp_rdata | output | DATA_W | Value read from the PHY |
| bus_wval | output | DATA_W | Address or data toward the PHY |
| bus_cap_addr | output | 1 | Address-capture strobe |
| bus_cap_data | output | 1 | Data-capture strobe |
| bus_rd_stb | output | 1 | Read strobe |
| bus_wr_stb | output | 1 | Write strobe |
| bus_rval | input | DATA_W | Read value from the PHY |
| bus_ack | input | 1 | Acknowledge from the PHY, asynchronous |

## Verification
Two things can land on the same acknowledge sample: the expected acknowledge level and the expiry of the timeout window. The bench provokes this with a PHY model whose acknowledge delay can be tuned. A delay just inside the window must complete every phase without error, and a delay just beyond it must abort with the error flag and leave no strobe behind. The bench also holds a new request valid while a response pulse is being produced. It judges that the request is taken only in the cycle after the pulse, and that the scoreboard sees the responses in order.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_RMW   = 2'd2,
        OP_ALT   = 2'd3
    } regbus_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR_SET,
        S_ADDR_STB,
        S_ADDR_REL,
        S_RD_SET,
        S_RD_STB,
        S_RD_REL,
        S_DAT_SET,
        S_DAT_STB,
        S_DAT_REL,
        S_WR_SET,
        S_WR_STB,
        S_WR_REL,
        S_RESP
    } regbus_state_e;

endpackage

// File: rtl/regbus_ack_sync.sv
module regbus_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES < 2) begin : g_bad
            initial $error("regbus_ack_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/regbus_poll_timer.sv
module regbus_poll_timer #(
    parameter int SAMPLE_CYCLES = 2,
    parameter int SAMPLE_LIMIT  = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick,
    output logic last_sample
);
    localparam int CW = $clog2(SAMPLE_CYCLES + 1);
    localparam int NW = $clog2(SAMPLE_LIMIT + 1);

    typedef struct packed {
        logic [CW-1:0] cyc;
        logic [NW-1:0] smp;
    } tmr_t;

    tmr_t q, d;

    assign tick        = (q.cyc == CW'(SAMPLE_CYCLES - 1));
    assign last_sample = tick && (q.smp == NW'(SAMPLE_LIMIT - 1));

    always_comb begin
        d = q;
        if (restart) begin
            d = '0;
        end else if (tick) begin
            d.cyc = '0;
            d.smp = q.smp + NW'(1);
        end else begin
            d.cyc = q.cyc + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/regbus_master.sv
module regbus_master
    import regbus_pkg::*;
#(
    parameter int DATA_W        = 16,
    parameter int SAMPLE_CYCLES = 2,
    parameter int SAMPLE_LIMIT  = 200,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [DATA_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] req_mask,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [DATA_W-1:0] bus_wval,
    output logic              bus_cap_addr,
    output logic              bus_cap_data,
    output logic              bus_rd_stb,
    output logic              bus_wr_stb,
    input  logic [DATA_W-1:0] bus_rval,
    input  logic              bus_ack
);
    typedef struct packed {
        regbus_state_e     state;
        regbus_op_e        op;
        logic [DATA_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] rdata;
        logic              second;
        logic              setup;
        logic              err;
    } seq_t;

    seq_t seq_q, seq_d;
    logic ack_s, tick, last_sample, tmr_restart;
    logic seen_hi, seen_lo;

    regbus_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(bus_ack), .sync_out(ack_s)
    );

    regbus_poll_timer #(
        .SAMPLE_CYCLES(SAMPLE_CYCLES), .SAMPLE_LIMIT(SAMPLE_LIMIT)
    ) u_tmr (
        .clk(clk), .rst(rst), .restart(tmr_restart),
        .tick(tick), .last_sample(last_sample)
    );

    assign seen_hi = tick && ack_s;
    assign seen_lo = tick && !ack_s;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            S_IDLE: if (req_valid) begin
                seq_d.state  = S_ADDR_SET;
                seq_d.op     = regbus_op_e'(req_op);
                seq_d.addr   = req_addr;
                seq_d.wdata  = req_wdata;
                seq_d.mask   = req_mask;
                seq_d.rdata  = '0;
                seq_d.second = 1'b0;
                seq_d.setup  = 1'b0;
                seq_d.err    = 1'b0;
            end
            S_ADDR_SET: begin
                seq_d.setup = !seq_q.setup;
                if (seq_q.setup) seq_d.state = S_ADDR_STB;
            end
            S_ADDR_STB: if (seen_hi)          seq_d.state = S_ADDR_REL;
                        else if (last_sample) seq_d.err   = 1'b1;
            S_ADDR_REL: if (seen_lo)
                            seq_d.state = (seq_q.op == OP_WRITE || seq_q.second)
                                          ? S_DAT_SET : S_RD_SET;
                        else if (last_sample) seq_d.err = 1'b1;
            S_RD_SET:   seq_d.state = S_RD_STB;
            S_RD_STB: if (seen_hi) begin
                          seq_d.rdata = bus_rval;
                          seq_d.state = S_RD_REL;
                      end else if (last_sample) seq_d.err = 1'b1;
            S_RD_REL: if (seen_lo) begin
                          if (seq_q.op == OP_RMW) begin
                              seq_d.wdata  = (seq_q.rdata & ~seq_q.mask) | seq_q.wdata;
                              seq_d.second = 1'b1;
                              seq_d.state  = S_ADDR_SET;
                          end else begin
                              seq_d.state = S_RESP;
                          end
                      end else if (last_sample) seq_d.err = 1'b1;
            S_DAT_SET: begin
                seq_d.setup = !seq_q.setup;
                if (seq_q.setup) seq_d.state = S_DAT_STB;
            end
            S_DAT_STB: if (seen_hi)          seq_d.state = S_DAT_REL;
                       else if (last_sample) seq_d.err   = 1'b1;
            S_DAT_REL: if (seen_lo)          seq_d.state = S_WR_SET;
                       else if (last_sample) seq_d.err   = 1'b1;
            S_WR_SET:  seq_d.state = S_WR_STB;
            S_WR_STB:  if (seen_hi)          seq_d.state = S_WR_REL;
                       else if (last_sample) seq_d.err   = 1'b1;
            S_WR_REL:  if (seen_lo)          seq_d.state = S_RESP;
                       else if (last_sample) seq_d.err   = 1'b1;
            S_RESP:    seq_d.state = S_IDLE;
            default:   seq_d.state = S_IDLE;
        endcase
        // a timed-out phase ends the command with no data
        if (seq_d.err && !seq_q.err) begin
            seq_d.state = S_RESP;
            seq_d.rdata = '0;
        end
        tmr_restart = (seq_d.state != seq_q.state);
    end

    always_ff @(posedge clk) begin
        if (rst) seq_q <= '0;
        else     seq_q <= seq_d;
    end

    always_comb begin
        bus_wval     = '0;
        bus_cap_addr = 1'b0;
        bus_cap_data = 1'b0;
        bus_rd_stb   = 1'b0;
        bus_wr_stb   = 1'b0;
        unique case (seq_q.state)
            S_ADDR_SET, S_ADDR_REL: bus_wval = seq_q.addr;
            S_ADDR_STB: begin bus_wval = seq_q.addr; bus_cap_addr = 1'b1; end
            S_RD_STB:   bus_rd_stb = 1'b1;
            S_DAT_SET, S_DAT_REL, S_WR_SET, S_WR_REL: bus_wval = seq_q.wdata;
            S_DAT_STB:  begin bus_wval = seq_q.wdata; bus_cap_data = 1'b1; end
            S_WR_STB:   begin bus_wval = seq_q.wdata; bus_wr_stb = 1'b1; end
            default: ;
        endcase
    end

    assign req_ready = (seq_q.state == S_IDLE);
    assign rsp_valid = (seq_q.state == S_RESP);
    assign rsp_err   = rsp_valid && seq_q.err;
    assign rsp_rdata = seq_q.rdata;
endmodule

// File: rtl/regbus_master_chk.sv
module regbus_master_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] bus_wval,
    input logic              bus_cap_addr,
    input logic              bus_cap_data,
    input logic              bus_rd_stb,
    input logic              bus_wr_stb
);
    a_r6_single_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({bus_cap_addr, bus_cap_data, bus_rd_stb, bus_wr_stb}));

    a_r1_addr_setup: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_cap_addr) |-> $stable(bus_wval));

    a_r2_read_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rd_stb |-> (bus_wval == '0));

    a_r3_write_setup: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_wr_stb) |-> $stable(bus_wval));

    a_r3_write_hold: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_stb && $past(bus_wr_stb)) |-> $stable(bus_wval));

    a_r7_one_outstanding: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    a_r7_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    a_r7_busy_at_rsp: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);
endmodule

bind regbus_master regbus_master_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .bus_wval(bus_wval),
    .bus_cap_addr(bus_cap_addr), .bus_cap_data(bus_cap_data),
    .bus_rd_stb(bus_rd_stb), .bus_wr_stb(bus_wr_stb)
);

// File: tb/tb_regbus_master.sv
module tb_regbus_master;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = '0;
    logic [DW-1:0] req_addr = '0, req_wdata = '0, req_mask = '0;
    logic          rsp_valid, rsp_err;
    logic [DW-1:0] rsp_rdata, bus_wval;
    logic          bus_cap_addr, bus_cap_data, bus_rd_stb, bus_wr_stb;
    logic [DW-1:0] bus_rval = '0;
    logic          bus_ack = 1'b0;

    always #5 clk = ~clk;

    regbus_master #(.DATA_W(DW), .SAMPLE_CYCLES(2), .SAMPLE_LIMIT(200)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .bus_wval(bus_wval),
        .bus_cap_addr(bus_cap_addr), .bus_cap_data(bus_cap_data),
        .bus_rd_stb(bus_rd_stb), .bus_wr_stb(bus_wr_stb),
        .bus_rval(bus_rval), .bus_ack(bus_ack)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---------------- PHY model ----------------
    logic [DW-1:0] phy_mem [16];
    logic [DW-1:0] shadow  [16];
    logic [DW-1:0] lat_addr = '0, lat_data = '0;
    int ack_delay = 3;
    int fault     = 0;   // 1: never raise ack, 2: never drop ack
    int wr_count  = 0;

    function automatic bit any_stb();
        return bus_cap_addr || bus_cap_data || bus_rd_stb || bus_wr_stb;
    endfunction

    initial begin
        forever begin
            @(negedge clk);
            if (!bus_ack && any_stb() && fault != 1) begin
                repeat (ack_delay) @(negedge clk);
                if (any_stb() && fault != 1) begin
                    if (bus_cap_addr)      lat_addr = bus_wval;
                    else if (bus_cap_data) lat_data = bus_wval;
                    else if (bus_rd_stb)   bus_rval = phy_mem[lat_addr[3:0]];
                    else begin
                        phy_mem[lat_addr[3:0]] = lat_data;
                        wr_count++;
                    end
                    bus_ack = 1'b1;
                    while (any_stb()) @(negedge clk);
                    while (fault == 2) @(negedge clk);
                    repeat (ack_delay) @(negedge clk);
                    bus_ack = 1'b0;
                end
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit            err;
        logic [DW-1:0] rdata;
        string         req;
    } exp_t;
    exp_t exp_q[$];
    int   outstanding = 0;

    task automatic send(input logic [1:0] op, input logic [DW-1:0] a,
                        input logic [DW-1:0] wd, input logic [DW-1:0] m,
                        input bit e_err, input logic [DW-1:0] e_rd, input string req);
        exp_t it;
        it.err = e_err; it.rdata = e_rd; it.req = req;
        exp_q.push_back(it);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd; req_mask = m;
        while (!req_ready) @(negedge clk);
        outstanding++;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        int n = 0;
        while (exp_q.size() != 0 && n < 20000) begin
            @(negedge clk);
            n++;
        end
        repeat (4) @(negedge clk);
    endtask

    bit prev_rsp = 0;
    logic [3:0]    stb_prev = '0;
    logic [DW-1:0] wval_prev = '0;
    int setup_cnt = 0;

    // monitors sample 1 ns after the rising edge
    always begin
        @(posedge clk);
        #1;
        if (!rst) begin
            logic [3:0] stb;
            stb = {bus_cap_addr, bus_cap_data, bus_rd_stb, bus_wr_stb};
            if (rsp_valid) begin
                outstanding--;
                if (exp_q.size() == 0) begin
                    chk(0, "R7", "response with nothing pending", 1, 0);
                end else begin
                    exp_t it;
                    it = exp_q.pop_front();
                    chk(rsp_err == it.err, it.req, "rsp_err", 32'(rsp_err), 32'(it.err));
                    chk(rsp_rdata == it.rdata, it.req, "rsp_rdata", 32'(rsp_rdata), 32'(it.rdata));
                end
            end
            if (rsp_valid && prev_rsp) chk(0, "R7", "rsp_valid longer than one cycle", 1, 0);
            if (req_ready && outstanding > 0) chk(0, "R7", "ready while busy", 32'(outstanding), 0);
            if (stb != 4'b0 && stb != stb_prev)
                chk($countones(stb) <= 1, "R6", "strobes high together", 32'(stb), 0);
            if (bus_cap_addr && !stb_prev[3])
                chk(setup_cnt >= 2 && bus_wval == wval_prev, "R1", "address setup cycles",
                    32'(setup_cnt), 2);
            if (!bus_cap_addr && stb_prev[3] && stb == 4'b0 && !rsp_valid)
                chk(bus_wval == wval_prev, "R1", "address held after strobe drop",
                    32'(bus_wval), 32'(wval_prev));
            if (bus_rd_stb && !stb_prev[1])
                chk(bus_wval == '0, "R2", "read phase value", 32'(bus_wval), 0);
            if (bus_wr_stb && !stb_prev[0])
                chk(bus_wval == lat_data && bus_wval == wval_prev, "R3", "write strobe value",
                    32'(bus_wval), 32'(lat_data));
            if (stb == 4'b0) setup_cnt = (bus_wval == wval_prev) ? setup_cnt + 1 : 1;
            prev_rsp  = rsp_valid;
            stb_prev  = stb;
            wval_prev = bus_wval;
        end else begin
            prev_rsp = 0; stb_prev = '0; wval_prev = '0; setup_cnt = 0;
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        int wc;
        logic [DW-1:0] merged;
        for (int i = 0; i < 16; i++) begin
            phy_mem[i] = DW'(16'h1000 + i * 16'h0111);
            shadow[i]  = phy_mem[i];
        end
        repeat (5) @(negedge clk);
        chk(req_ready == 1'b1, "R8", "ready in reset", 32'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R8", "rsp_valid in reset", 32'(rsp_valid), 0);
        chk(!any_stb(), "R8", "strobes in reset", 32'(any_stb()), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R2 plain read
        send(2'd0, 16'h0003, '0, '0, 0, shadow[3], "R2");
        drain();
        // R3 plain write then read back
        send(2'd1, 16'h0005, 16'hA5C3, '0, 0, '0, "R3");
        shadow[5] = 16'hA5C3;
        drain();
        chk(phy_mem[5] == 16'hA5C3, "R3", "written register", 32'(phy_mem[5]), 32'hA5C3);
        send(2'd0, 16'h0005, '0, '0, 0, 16'hA5C3, "R3");
        drain();
        // R4 read-modify-write
        merged = (shadow[5] & ~16'h00F0) | 16'h0009;
        send(2'd2, 16'h0005, 16'h0009, 16'h00F0, 0, shadow[5], "R4");
        shadow[5] = merged;
        drain();
        chk(phy_mem[5] == 16'hA50B, "R4", "merged register", 32'(phy_mem[5]), 32'hA50B);
        // R7 back-to-back requests, second held while busy
        send(2'd1, 16'h100A, 16'h1234, '0, 0, '0, "R7");
        shadow[10] = 16'h1234;
        send(2'd0, 16'h100A, '0, '0, 0, 16'h1234, "R7");
        drain();
        // R2 alternate opcode behaves as read
        wc = wr_count;
        send(2'd3, 16'h0007, 16'hFFFF, 16'hFFFF, 0, shadow[7], "R2");
        drain();
        chk(wr_count == wc, "R2", "opcode 3 issued a write", 32'(wr_count), 32'(wc));

        // R5 acknowledge just inside the window
        ack_delay = 380;
        send(2'd0, 16'h0009, '0, '0, 0, shadow[9], "R5");
        drain();
        // R5 acknowledge just outside the window
        ack_delay = 420;
        send(2'd0, 16'h0009, '0, '0, 1, '0, "R5");
        drain();
        chk(!any_stb(), "R5", "strobes after timeout", 32'(any_stb()), 0);
        repeat (500) @(negedge clk);
        ack_delay = 3;

        // R5 never acknowledged: write must not reach the write strobe
        fault = 1;
        wc = wr_count;
        send(2'd1, 16'h0002, 16'hDEAD, '0, 1, '0, "R5");
        drain();
        chk(wr_count == wc, "R5", "write issued after timeout", 32'(wr_count), 32'(wc));
        chk(phy_mem[2] == shadow[2], "R5", "register after timeout", 32'(phy_mem[2]), 32'(shadow[2]));
        fault = 0;
        repeat (20) @(negedge clk);

        // R5 acknowledge stuck high: release phase times out
        fault = 2;
        wc = wr_count;
        send(2'd1, 16'h0004, 16'hBEEF, '0, 1, '0, "R5");
        drain();
        chk(wr_count == wc, "R5", "write issued after stuck ack", 32'(wr_count), 32'(wc));
        fault = 0;
        repeat (20) @(negedge clk);

        // R8 reset during a command
        ack_delay = 40;
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd1; req_addr = 16'h0006; req_wdata = 16'h5555;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!any_stb(), "R8", "strobes after mid-command reset", 32'(any_stb()), 0);
        chk(req_ready == 1'b1, "R8", "ready after mid-command reset", 32'(req_ready), 1);
        rst = 1'b0;
        outstanding = 0;
        repeat (100) @(negedge clk);
        ack_delay = 3;
        send(2'd0, 16'h0006, '0, '0, 0, shadow[6], "R8");
        drain();

        begin
            int bad = 0;
            for (int i = 0; i < 16; i++) if (phy_mem[i] !== shadow[i]) bad++;
            chk(bad == 0, "R3", "register file contents", 32'(bad), 0);
        end
        chk(exp_q.size() == 0, "R7", "responses missing", 32'(exp_q.size()), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule